// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block takes one serial data line, together with the serial clock that travels with it, and recovers fixed 35-bit frames from it. An idle line sits low. A frame opens with a high start bit, carries a 32-bit word, then one parity bit, and ends with a low stop bit. The bits are plain serial levels. No line coding is used, and every bit is sampled on a rising edge of the incoming serial clock.

A frame that passes its checks is placed in a single output holding register, and a ready flag is raised in the system clock domain. The word stays in that register until a downstream poller sends a one-cycle acknowledge, which frees the register for the next frame. The ready level and the acknowledge cross between the two clock domains through two-flop synchronizers and form a four-phase handshake. Frames that fail the parity check or that arrive while the register is still occupied are discarded, and each failure sets its own sticky error flag.

Top module: `frame_rx`

## Requirements
- R1: On each rising edge of `serClk` the receiver samples `serData`. While idle it waits for a 1, which is the start bit. It then takes 32 data bits, with the first bit after the start bit landing in `wordOut[31]` and the last in `wordOut[0]`. One parity bit and one stop bit follow. A good frame is delivered on `wordOut` unchanged.
- R2: Parity is odd. The 32 data bits and the parity bit together must hold an odd number of ones. A frame with a good stop bit and a parity mismatch is discarded, and `parityErr` is set.
- R3: A frame whose stop bit is 1 is discarded with no flag set. The receiver then goes back to waiting for a start bit.
- R4: A short synchronizer delay after a good frame is stored, `wordReady` rises. While `wordReady` is high and no acknowledge is given, `wordOut` holds its value.
- R5: A one-cycle `wordAck` pulse while `wordReady` is high drops `wordReady` on the next `sysClk` cycle. Once the handshake has settled, the following frame is delivered.
- R6: A `wordAck` pulse while `wordReady` is low has no effect, and the next frame is delivered normally.
- R7: If a good frame completes while the holding register is still occupied, that new word is dropped and `overflowErr` is set. The held word is unchanged.
- R8: During and after reset, `wordReady`, `parityErr` and `overflowErr` are 0.
- R9: `parityErr` and `overflowErr` stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| serClk | input | 1 | Serial clock that arrives with the data line |
| serData | input | 1 | Serial data line, idle low |
| sysClk | input | 1 | System clock of the downstream poller |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wordAck | input | 1 | One-cycle acknowledge from the poller (sysClk) |
| wordOut | output | 32 | Held received word |
| wordReady | output | 1 | A held word is available (sysClk) |
| parityErr | output | 1 | Sticky flag for a parity failure (sysClk) |
| overflowErr | output | 1 | Sticky flag for a word dropped while the register was full (sysClk) |

## Verification
The bench sends a walking one through all 32 data positions, along with all-zero, all-one, alternating and arithmetically spread words. It computes each parity bit itself. This shows whether bit order, the bit count and the parity polarity are each correct. Frames with a flipped parity bit or a high stop bit must produce no word, and they also tell the parity path apart from the framing path through which flag, if any, is raised. Two frames sent back to back with no acknowledge between them separate the overflow drop from an overwrite of the held word. A stray acknowledge sent while no word is ready shows that the handshake ignores it.

// File: rtl/frx_pkg.sv
`timescale 1ns/1ps
package frx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic capPar;
    logic loadHold;
  } rxStrobe_t;
endpackage

// File: rtl/frx_sync.sv
`timescale 1ns/1ps
module frx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/frx_datapath.sv
`timescale 1ns/1ps
module frx_datapath
  import frx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              serClk,
  input  logic              rstN,
  input  logic              serData,
  input  rxStrobe_t         strobe,
  output logic              parityOk,
  output logic [DATA_W-1:0] holdReg
);
  logic [DATA_W-1:0] shiftReg;
  logic              parBit;

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      holdReg  <= '0;
    end else begin
      if (strobe.shiftEn)  shiftReg <= {shiftReg[DATA_W-2:0], serData};
      if (strobe.capPar)   parBit   <= serData;
      if (strobe.loadHold) holdReg  <= shiftReg;
    end
  end

  // odd parity: data plus parity bit must carry an odd count of ones
  assign parityOk = ^{shiftReg, parBit};
endmodule

// File: rtl/frx_ctrl.sv
`timescale 1ns/1ps
module frx_ctrl
  import frx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic      serClk,
  input  logic      rstN,
  input  logic      serData,
  input  logic      parityOk,
  input  logic      ackSeen,
  output rxStrobe_t strobe,
  output logic      fullQ,
  output logic      parityErrQ,
  output logic      overflowQ
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  rxState_t         state;
  logic [CNT_W-1:0] bitCnt;
  logic             stopOk;
  logic             frameGood;
  logic             canAccept;

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (serData) begin
          state  <= ST_DATA;
          bitCnt <= '0;
        end
        ST_DATA: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) state <= ST_PAR;
        end
        ST_PAR:  state <= ST_STOP;
        ST_STOP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stopOk          = (state == ST_STOP) && !serData;
    frameGood       = stopOk && parityOk;
    canAccept       = !fullQ && !ackSeen;
    strobe.shiftEn  = (state == ST_DATA);
    strobe.capPar   = (state == ST_PAR);
    strobe.loadHold = frameGood && canAccept;
  end

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      fullQ      <= 1'b0;
      parityErrQ <= 1'b0;
      overflowQ  <= 1'b0;
    end else begin
      if (strobe.loadHold)         fullQ      <= 1'b1;
      else if (ackSeen)            fullQ      <= 1'b0;
      if (stopOk && !parityOk)     parityErrQ <= 1'b1;
      if (frameGood && !canAccept) overflowQ  <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_rx.sv
`timescale 1ns/1ps
module frame_rx
  import frx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              serClk,
  input  logic              serData,
  input  logic              sysClk,
  input  logic              rstN,
  input  logic              wordAck,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordReady,
  output logic              parityErr,
  output logic              overflowErr
);
  rxStrobe_t strobe;
  logic      parityOk;
  logic      fullQ;
  logic      parityErrQ;
  logic      overflowQ;
  logic      ackSeen;
  logic      readySync;
  logic      ackLevel;

  frx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .serClk(serClk), .rstN(rstN), .serData(serData), .parityOk(parityOk),
    .ackSeen(ackSeen), .strobe(strobe), .fullQ(fullQ),
    .parityErrQ(parityErrQ), .overflowQ(overflowQ)
  );

  frx_datapath #(.DATA_W(DATA_W)) u_dp (
    .serClk(serClk), .rstN(rstN), .serData(serData), .strobe(strobe),
    .parityOk(parityOk), .holdReg(wordOut)
  );

  frx_sync #(.STAGES(SYNC_STAGES)) u_syncReady (
    .clk(sysClk), .rstN(rstN), .d(fullQ), .q(readySync));
  frx_sync #(.STAGES(SYNC_STAGES)) u_syncAck (
    .clk(serClk), .rstN(rstN), .d(ackLevel), .q(ackSeen));
  frx_sync #(.STAGES(SYNC_STAGES)) u_syncPar (
    .clk(sysClk), .rstN(rstN), .d(parityErrQ), .q(parityErr));
  frx_sync #(.STAGES(SYNC_STAGES)) u_syncOvf (
    .clk(sysClk), .rstN(rstN), .d(overflowQ), .q(overflowErr));

  // ack level held until the serial side drops its full flag
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)                      ackLevel <= 1'b0;
    else if (wordAck && wordReady)  ackLevel <= 1'b1;
    else if (!readySync)            ackLevel <= 1'b0;
  end

  assign wordReady = readySync && !ackLevel;
endmodule

// File: rtl/frx_checker.sv
`timescale 1ns/1ps
module frx_checker (
  input logic        sysClk,
  input logic        serClk,
  input logic        rstN,
  input logic        serData,
  input logic        wordAck,
  input logic        wordReady,
  input logic [31:0] wordOut,
  input logic        parityErr,
  input logic        overflowErr,
  input logic        holdFull
);
  // R5
  ack_clears_ready_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    wordAck && wordReady |=> !wordReady);

  // R4
  held_word_stable_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    wordReady && !wordAck |=> $stable(wordOut));

  // R9
  parity_sticky_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    parityErr |=> parityErr);

  // R9
  overflow_sticky_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    overflowErr |=> overflowErr);

  // R3
  load_needs_stop_chk: assert property (@(posedge serClk) disable iff (!rstN)
    $rose(holdFull) |-> !$past(serData));
endmodule

bind frame_rx frx_checker i_chk (
  .sysClk(sysClk), .serClk(serClk), .rstN(rstN), .serData(serData),
  .wordAck(wordAck), .wordReady(wordReady), .wordOut(wordOut),
  .parityErr(parityErr), .overflowErr(overflowErr), .holdFull(fullQ)
);

// File: tb/test_frame_rx.sv
`timescale 1ns/1ps
module test_frame_rx;
  logic        sysClk = 1'b0;
  logic        serClk = 1'b0;
  logic        rstN = 1'b0;
  logic        serData = 1'b0;
  logic        wordAck = 1'b0;
  logic [31:0] wordOut;
  logic        wordReady;
  logic        parityErr;
  logic        overflowErr;
  int          checks = 0;
  int          errors = 0;

  always #2.5 sysClk = ~sysClk;
  always #6.5 serClk = ~serClk;

  frame_rx i_frame_rx (
    .serClk(serClk), .serData(serData), .sysClk(sysClk), .rstN(rstN),
    .wordAck(wordAck), .wordOut(wordOut), .wordReady(wordReady),
    .parityErr(parityErr), .overflowErr(overflowErr)
  );

  function automatic logic oddPar(input logic [31:0] d);
    return ~^d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [31:0] d, input logic p, input logic s);
    logic [34:0] vec;
    vec = {1'b1, d, p, s};
    for (int i = 34; i >= 0; i--) begin
      @(negedge serClk) serData = vec[i];
    end
    @(negedge serClk) serData = 1'b0;
  endtask

  task automatic waitReady(output bit got);
    got = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge sysClk);
      if (wordReady) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic settle();
    repeat (30) @(negedge sysClk);
  endtask

  task automatic doAck();
    @(negedge sysClk) wordAck = 1'b1;
    @(negedge sysClk) wordAck = 1'b0;
    check(wordReady == 1'b0, "R5 ready drop", 32'(wordReady), 32'h0);
  endtask

  task automatic expectWord(input logic [31:0] d, input string req);
    bit got;
    sendFrame(d, oddPar(d), 1'b0);
    waitReady(got);
    check(got, {req, " ready"}, 32'(got), 32'h1);
    check(wordOut == d, {req, " data"}, wordOut, d);
    doAck();
    settle();
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    repeat (5) @(negedge sysClk);
    // R8 reset state
    check(wordReady == 1'b0, "R8 ready", 32'(wordReady), 32'h0);
    check(parityErr == 1'b0, "R8 parity", 32'(parityErr), 32'h0);
    check(overflowErr == 1'b0, "R8 overflow", 32'(overflowErr), 32'h0);
    rstN = 1'b1;
    settle();

    // R1 bit order: walking one over every position
    for (int i = 0; i < 32; i++) expectWord(32'h1 << i, "R1 walk");
    expectWord(32'h0000_0000, "R1 zeros");
    expectWord(32'hFFFF_FFFF, "R1 ones");
    expectWord(32'hAAAA_5555, "R1 alternating");
    for (int i = 1; i <= 6; i++) expectWord(32'(i) * 32'h9E37_79B9, "R4 spread");

    // R6 stray ack while not ready
    @(negedge sysClk) wordAck = 1'b1;
    @(negedge sysClk) wordAck = 1'b0;
    check(wordReady == 1'b0, "R6 no ready", 32'(wordReady), 32'h0);
    settle();
    expectWord(32'h1357_2468, "R6 after stray ack");

    // R3 bad stop bit
    sendFrame(32'hC0DE_0001, oddPar(32'hC0DE_0001), 1'b1);
    settle();
    check(wordReady == 1'b0, "R3 dropped", 32'(wordReady), 32'h0);
    check(parityErr == 1'b0, "R3 no parity flag", 32'(parityErr), 32'h0);
    check(overflowErr == 1'b0, "R3 no overflow flag", 32'(overflowErr), 32'h0);
    expectWord(32'h0BAD_F00D, "R3 recovery");

    // R2 parity mismatch
    sendFrame(32'h1234_5678, ~oddPar(32'h1234_5678), 1'b0);
    settle();
    check(wordReady == 1'b0, "R2 dropped", 32'(wordReady), 32'h0);
    check(parityErr == 1'b1, "R2 flag", 32'(parityErr), 32'h1);
    check(overflowErr == 1'b0, "R2 no overflow", 32'(overflowErr), 32'h0);
    expectWord(32'h8765_4321, "R2 recovery");
    check(parityErr == 1'b1, "R9 parity sticky", 32'(parityErr), 32'h1);

    // R7 overflow: two frames with no ack between
    sendFrame(32'hAAAA_0001, oddPar(32'hAAAA_0001), 1'b0);
    sendFrame(32'hBBBB_0002, oddPar(32'hBBBB_0002), 1'b0);
    waitReady(got);
    settle();
    check(got, "R7 ready", 32'(got), 32'h1);
    check(wordOut == 32'hAAAA_0001, "R7 held word", wordOut, 32'hAAAA_0001);
    check(overflowErr == 1'b1, "R7 flag", 32'(overflowErr), 32'h1);
    doAck();
    settle();
    expectWord(32'hCCCC_0003, "R7 recovery");
    check(overflowErr == 1'b1, "R9 overflow sticky", 32'(overflowErr), 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule